// File: doc/BRIEF.md
# Timer External Input Event Router

This block sits between two asynchronous timer input pins, A and B, and the counting core of a general-purpose timer. Each pin is brought into the system clock domain by a short flop chain. Each pin then goes through its own edge detector, which can be set to the rising edge, the falling edge, both edges, or nothing. A 4-bit mode value gives each pin a role. The roles are gate, trigger, external clock, clock up or clock down, direction select, and lead/lag autodiscrimination. From these roles the block forms single-cycle command strobes for the counter, plus a registered gate level.

Mode value, trigger meaning and the bivalue mask are plain input ports. They are normally held steady by the timer's configuration logic while the pins are active. The counter, the capture and compare registers and the interrupt logic are outside this block. They only consume its outputs.

Top module: `tmr_evt_router`

## Requirements
- R1: With a single-edge selector, a qualifying pin change driven between clock edges shows up as a strobe after the third rising clock edge. The strobe stays high for exactly one cycle.
- R2: Edge selector encoding per pin: 00 detects nothing, 01 detects rising edges, 10 detects falling edges, 11 detects both edges. Each qualifying edge produces exactly one strobe.
- R3: When a pin uses both edges, or when autodiscrimination is selected (mode 1100), that pin is sampled only on a prescaler tick, one system clock in three. Levels held for eight clocks are never missed.
- R4: Pin A is a trigger in modes 0101, 0111, 1101 and 1111. In those modes an A event pulses `cntLoad` when `trigCapSel`=0 and pulses `capReg0` when `trigCapSel`=1.
- R5: Pin B is a trigger in modes 0001, 0011, 0111 and 1110. In those modes a B event pulses `capReg1`.
- R6: While `bivalueMode`=1, every pin B edge event is discarded, and a pin B gate is treated as open (level 1).
- R7: Pin B is an external clock in modes 0100, 0110, 1001 and 1101, and pin A is an external clock in mode 1110. Each event pulses `cntEn` with `cntUp`. The exception is mode 1001, where the synchronized A level picks the direction: high gives `cntUp`, low gives `cntDn`.
- R8: `gateLvl` is the AND of the synchronized levels of the pins in gate role (A in 0010, 0011 and 0110; B in 1111). It is 1 when no pin is a gate, including right after reset. In mode 0110, external clock events count only while the gate is high.
- R9: Mode 1000 gives one up count (`cntEn`+`cntUp`) per A event and one down count (`cntEn`+`cntDn`) per B event. Events on both pins in the same cycle cancel and produce no count.
- R10: Mode 1010 produces `cntUp` alone on an A event and `cntDn` alone on a B event. It never produces `cntEn`, a load or a capture, whatever `trigCapSel` is.
- R11: In mode 1100, an A event counts up while pin B is low and counts down while pin B is high. Pin B edges produce nothing.
- R12: Whenever `cntEn` is high, exactly one of `cntUp` and `cntDn` is high.
- R13: Modes 0000 and 1011 produce no strobes from either pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinA | input | 1 | External input A, asynchronous |
| pinB | input | 1 | External input B, asynchronous |
| edgeSelA | input | 2 | Edge selector for A (00 off, 01 rise, 10 fall, 11 both) |
| edgeSelB | input | 2 | Edge selector for B (same encoding) |
| mode | input | 4 | Pin role mode |
| trigCapSel | input | 1 | A trigger meaning: 0 load, 1 capture into register 0 |
| bivalueMode | input | 1 | Discards pin B events when 1 |
| cntEn | output | 1 | Count pulse |
| cntUp | output | 1 | Up direction (with cntEn) or up start strobe (mode 1010) |
| cntDn | output | 1 | Down direction (with cntEn) or down start strobe (mode 1010) |
| cntLoad | output | 1 | Counter load strobe |
| capReg0 | output | 1 | Capture into register 0 strobe |
| capReg1 | output | 1 | Capture into register 1 strobe |
| gateLvl | output | 1 | Registered gate level |

## Verification
The assertions assume that mode, edge selectors, `trigCapSel` and `bivalueMode` stay stable while pins are toggling. A selector that changes just after an edge could otherwise turn one pin change into two back-to-back events. They also assume the pins are held for at least a few clocks, so that tick-rate sampling sees every level. The directed tests change configuration only with both pins held low, and then wait ten clocks before counting strobes. Every pin level is held for eight clocks, well above one prescaler period.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  typedef enum logic [2:0] {
    A_NONE, A_GATE, A_TRIG, A_CLKUP, A_UDSEL, A_TRIGUP, A_AUTO, A_EXTCLK
  } roleA_t;

  typedef enum logic [2:0] {
    B_NONE, B_TRIG, B_EXTCLK, B_CLKDN, B_TRIGDN, B_AUTO, B_GATE
  } roleB_t;

  // control -> datapath
  typedef struct packed {
    logic autoRate;
  } dpCfg_t;

  // datapath -> control
  typedef struct packed {
    logic evA;
    logic evB;
    logic lvlA;
    logic lvlB;
  } pinEvt_t;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

endpackage

// File: rtl/tmr_evt_datapath.sv
module tmr_evt_datapath
  import tmr_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinA,
  input  logic       pinB,
  input  logic [1:0] edgeSelA,
  input  logic [1:0] edgeSelB,
  input  dpCfg_t     cfg,
  output pinEvt_t    evt
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] preCnt;
  logic          tick;

  assign tick = (preCnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  logic [1:0] pinIn;
  logic [1:0] lvl;
  logic [1:0] ev;
  logic [1:0] sel [2];

  assign pinIn  = {pinB, pinA};
  assign sel[0] = edgeSelA;
  assign sel[1] = edgeSelB;

  for (genvar g = 0; g < 2; g++) begin : gPin
    logic [SYNC_STAGES-1:0] syncSh;
    logic prevLvl;
    logic slowRate;
    logic sampleEn;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncSh <= '0;
      else       syncSh <= {syncSh[SYNC_STAGES-2:0], pinIn[g]};
    end

    assign lvl[g]   = syncSh[SYNC_STAGES-1];
    assign slowRate = (sel[g] == EDGE_BOTH) || cfg.autoRate;
    assign sampleEn = !slowRate || tick;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         prevLvl <= 1'b0;
      else if (sampleEn) prevLvl <= lvl[g];
    end

    assign rise = sampleEn && lvl[g] && !prevLvl;
    assign fall = sampleEn && !lvl[g] && prevLvl;

    always_comb begin
      unique case (sel[g])
        EDGE_RISE: ev[g] = rise;
        EDGE_FALL: ev[g] = fall;
        EDGE_BOTH: ev[g] = rise || fall;
        default:   ev[g] = 1'b0;
      endcase
    end

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
      ev[g] |=> !ev[g]);  // R1
  end

  assign evt.evA  = ev[0];
  assign evt.evB  = ev[1];
  assign evt.lvlA = lvl[0];
  assign evt.lvlB = lvl[1];

endmodule

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] mode,
  input  logic       trigCapSel,
  input  logic       bivalueMode,
  input  pinEvt_t    evt,
  output dpCfg_t     cfg,
  output logic       cntEn,
  output logic       cntUp,
  output logic       cntDn,
  output logic       cntLoad,
  output logic       capReg0,
  output logic       capReg1,
  output logic       gateLvl
);

  roleA_t roleA;
  roleB_t roleB;

  always_comb begin
    unique case (mode)
      4'b0000: begin roleA = A_NONE;   roleB = B_NONE;   end
      4'b0001: begin roleA = A_NONE;   roleB = B_TRIG;   end
      4'b0010: begin roleA = A_GATE;   roleB = B_NONE;   end
      4'b0011: begin roleA = A_GATE;   roleB = B_TRIG;   end
      4'b0100: begin roleA = A_NONE;   roleB = B_EXTCLK; end
      4'b0101: begin roleA = A_TRIG;   roleB = B_NONE;   end
      4'b0110: begin roleA = A_GATE;   roleB = B_EXTCLK; end
      4'b0111: begin roleA = A_TRIG;   roleB = B_TRIG;   end
      4'b1000: begin roleA = A_CLKUP;  roleB = B_CLKDN;  end
      4'b1001: begin roleA = A_UDSEL;  roleB = B_EXTCLK; end
      4'b1010: begin roleA = A_TRIGUP; roleB = B_TRIGDN; end
      4'b1011: begin roleA = A_UDSEL;  roleB = B_NONE;   end
      4'b1100: begin roleA = A_AUTO;   roleB = B_AUTO;   end
      4'b1101: begin roleA = A_TRIG;   roleB = B_EXTCLK; end
      4'b1110: begin roleA = A_EXTCLK; roleB = B_TRIG;   end
      default: begin roleA = A_TRIG;   roleB = B_GATE;   end
    endcase
  end

  assign cfg.autoRate = (roleA == A_AUTO);

  logic evA, evB, gateA, gateB, gateNow;
  logic upReq, dnReq, dirUpReq, dirDnReq, loadReq, cap0Req, cap1Req;

  assign evA     = evt.evA;
  assign evB     = evt.evB && !bivalueMode;
  assign gateA   = (roleA == A_GATE) ? evt.lvlA : 1'b1;
  assign gateB   = (roleB == B_GATE && !bivalueMode) ? evt.lvlB : 1'b1;
  assign gateNow = gateA && gateB;

  always_comb begin
    upReq = 1'b0; dnReq = 1'b0; dirUpReq = 1'b0; dirDnReq = 1'b0;
    loadReq = 1'b0; cap0Req = 1'b0; cap1Req = 1'b0;

    unique case (roleA)
      A_TRIG:   if (evA) begin
                  if (trigCapSel) cap0Req = 1'b1;
                  else            loadReq = 1'b1;
                end
      A_CLKUP:  if (evA) upReq = 1'b1;
      A_TRIGUP: if (evA) dirUpReq = 1'b1;
      A_EXTCLK: if (evA && gateNow) upReq = 1'b1;
      A_AUTO:   if (evA) begin
                  if (evt.lvlB) dnReq = 1'b1;
                  else          upReq = 1'b1;
                end
      default: ;
    endcase

    unique case (roleB)
      B_TRIG:   if (evB) cap1Req = 1'b1;
      B_CLKDN:  if (evB) dnReq = 1'b1;
      B_TRIGDN: if (evB) dirDnReq = 1'b1;
      B_EXTCLK: if (evB && gateNow) begin
                  if (roleA == A_UDSEL && !evt.lvlA) dnReq = 1'b1;
                  else                               upReq = 1'b1;
                end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn   <= 1'b0;
      cntUp   <= 1'b0;
      cntDn   <= 1'b0;
      cntLoad <= 1'b0;
      capReg0 <= 1'b0;
      capReg1 <= 1'b0;
      gateLvl <= 1'b1;
    end else begin
      cntEn   <= upReq ^ dnReq;
      cntUp   <= (upReq && !dnReq) || dirUpReq;
      cntDn   <= (dnReq && !upReq) || dirDnReq;
      cntLoad <= loadReq;
      capReg0 <= cap0Req;
      capReg1 <= cap1Req;
      gateLvl <= gateNow;
    end
  end

  AST_DIR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |-> $onehot({cntUp, cntDn}));  // R12
  AST_BIV_MASK: assert property (@(posedge clk) disable iff (!rstN)
    capReg1 |-> !$past(bivalueMode));  // R6
  AST_LOAD_SEL: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> !$past(trigCapSel));  // R4
  AST_CAP0_SEL: assert property (@(posedge clk) disable iff (!rstN)
    capReg0 |-> $past(trigCapSel));  // R4
  AST_TRIGDIR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 4'b1010) |-> (!cntEn && !cntLoad && !capReg0 && !capReg1));  // R10
  AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && $past(mode) == 4'b0110) |-> gateLvl);  // R8

endmodule

// File: rtl/tmr_evt_router.sv
module tmr_evt_router
  import tmr_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinA,
  input  logic       pinB,
  input  logic [1:0] edgeSelA,
  input  logic [1:0] edgeSelB,
  input  logic [3:0] mode,
  input  logic       trigCapSel,
  input  logic       bivalueMode,
  output logic       cntEn,
  output logic       cntUp,
  output logic       cntDn,
  output logic       cntLoad,
  output logic       capReg0,
  output logic       capReg1,
  output logic       gateLvl
);

  dpCfg_t  cfg;
  pinEvt_t evt;

  tmr_evt_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .PRESCALE   (PRESCALE)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .pinA    (pinA),
    .pinB    (pinB),
    .edgeSelA(edgeSelA),
    .edgeSelB(edgeSelB),
    .cfg     (cfg),
    .evt     (evt)
  );

  tmr_evt_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .trigCapSel (trigCapSel),
    .bivalueMode(bivalueMode),
    .evt        (evt),
    .cfg        (cfg),
    .cntEn      (cntEn),
    .cntUp      (cntUp),
    .cntDn      (cntDn),
    .cntLoad    (cntLoad),
    .capReg0    (capReg0),
    .capReg1    (capReg1),
    .gateLvl    (gateLvl)
  );

endmodule

// File: tb/test_tmr_evt_router.sv
module test_tmr_evt_router;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinA = 1'b0, pinB = 1'b0;
  logic [1:0] edgeSelA = 2'b00, edgeSelB = 2'b00;
  logic [3:0] mode = 4'b0000;
  logic trigCapSel = 1'b0, bivalueMode = 1'b0;
  logic cntEn, cntUp, cntDn, cntLoad, capReg0, capReg1, gateLvl;

  always #4 clk = ~clk;

  tmr_evt_router i_tmr_evt_router (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB),
    .edgeSelA(edgeSelA), .edgeSelB(edgeSelB), .mode(mode),
    .trigCapSel(trigCapSel), .bivalueMode(bivalueMode),
    .cntEn(cntEn), .cntUp(cntUp), .cntDn(cntDn), .cntLoad(cntLoad),
    .capReg0(capReg0), .capReg1(capReg1), .gateLvl(gateLvl)
  );

  int nChecks = 0, nErrs = 0;
  int cUpCnt = 0, cDnCnt = 0, cUpOnly = 0, cDnOnly = 0;
  int cLoad = 0, cCap0 = 0, cCap1 = 0, cBadDir = 0;

  always @(negedge clk) if (rstN) begin
    if (cntEn && cntUp && !cntDn) cUpCnt++;
    if (cntEn && cntDn && !cntUp) cDnCnt++;
    if (cntEn && (cntUp == cntDn)) cBadDir++;
    if (!cntEn && cntUp) cUpOnly++;
    if (!cntEn && cntDn) cDnOnly++;
    if (cntLoad) cLoad++;
    if (capReg0) cCap0++;
    if (capReg1) cCap1++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts;
    @(posedge clk);
    cUpCnt = 0; cDnCnt = 0; cUpOnly = 0; cDnOnly = 0;
    cLoad = 0; cCap0 = 0; cCap1 = 0; cBadDir = 0;
  endtask

  task automatic setup(input logic [3:0] m, input logic [1:0] sa, input logic [1:0] sb,
                       input logic tcs, input logic biv);
    @(negedge clk);
    pinA = 1'b0; pinB = 1'b0;
    mode = m; edgeSelA = sa; edgeSelB = sb; trigCapSel = tcs; bivalueMode = biv;
    repeat (10) @(negedge clk);
    clearCounts();
  endtask

  task automatic driveA(input logic v);
    @(negedge clk); pinA = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic driveB(input logic v);
    @(negedge clk); pinB = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseA; driveA(1'b1); driveA(1'b0); endtask
  task automatic pulseB; driveB(1'b1); driveB(1'b0); endtask

  task automatic testReset;
    check("R8", "gateLvl after reset", int'(gateLvl), 1);
    check("R12", "strobes after reset",
          int'({cntEn, cntUp, cntDn, cntLoad, capReg0, capReg1}), 0);
  endtask

  task automatic testLatency;
    setup(4'b0101, 2'b01, 2'b00, 1'b0, 1'b0);
    @(negedge clk); pinA = 1'b1;
    @(negedge clk); check("R1", "load after 1 edge", int'(cntLoad), 0);
    @(negedge clk); check("R1", "load after 2 edges", int'(cntLoad), 0);
    @(negedge clk); check("R1", "load after 3 edges", int'(cntLoad), 1);
    @(negedge clk); check("R1", "load after 4 edges", int'(cntLoad), 0);
    repeat (6) @(negedge clk);
    driveA(1'b0);
    check("R4", "one load per rise, none on fall", cLoad, 1);
  endtask

  task automatic testEdgeSel;
    setup(4'b0101, 2'b10, 2'b00, 1'b0, 1'b0);
    pulseA(); pulseA();
    check("R2", "falling selector loads", cLoad, 2);
    setup(4'b0101, 2'b00, 2'b00, 1'b0, 1'b0);
    pulseA();
    check("R2", "disabled selector loads", cLoad, 0);
    setup(4'b0101, 2'b11, 2'b00, 1'b0, 1'b0);
    pulseA(); pulseA();
    check("R3", "both-edge selector loads", cLoad, 4);
  endtask

  task automatic testTrigA;
    setup(4'b0111, 2'b01, 2'b00, 1'b1, 1'b0);
    pulseA();
    check("R4", "capture0 with trigCapSel=1", cCap0, 1);
    check("R4", "no load with trigCapSel=1", cLoad, 0);
    setup(4'b1111, 2'b01, 2'b00, 1'b0, 1'b0);
    pulseA();
    check("R4", "load in mode 1111", cLoad, 1);
  endtask

  task automatic testTrigB;
    setup(4'b0001, 2'b00, 2'b01, 1'b0, 1'b0);
    pulseB(); pulseB();
    check("R5", "capture1 count", cCap1, 2);
    setup(4'b1110, 2'b00, 2'b11, 1'b0, 1'b0);
    pulseB();
    check("R5", "capture1 both edges mode 1110", cCap1, 2);
    setup(4'b0001, 2'b00, 2'b01, 1'b0, 1'b1);
    pulseB();
    check("R6", "capture1 with bivalue", cCap1, 0);
  endtask

  task automatic testExtClk;
    setup(4'b0100, 2'b00, 2'b01, 1'b0, 1'b0);
    pulseB(); pulseB(); pulseB();
    check("R7", "B ext clock up counts", cUpCnt, 3);
    check("R7", "B ext clock down counts", cDnCnt, 0);
    setup(4'b1001, 2'b00, 2'b01, 1'b0, 1'b0);
    driveA(1'b1);
    pulseB(); pulseB();
    check("R7", "dir select high -> up", cUpCnt, 2);
    driveA(1'b0);
    pulseB();
    check("R7", "dir select low -> down", cDnCnt, 1);
    setup(4'b1110, 2'b01, 2'b00, 1'b0, 1'b0);
    pulseA();
    check("R7", "A ext clock up count", cUpCnt, 1);
  endtask

  task automatic testGate;
    setup(4'b0110, 2'b00, 2'b01, 1'b0, 1'b0);
    check("R8", "gate closed level", int'(gateLvl), 0);
    pulseB(); pulseB();
    check("R8", "counts with gate closed", cUpCnt, 0);
    driveA(1'b1);
    check("R8", "gate open level", int'(gateLvl), 1);
    pulseB(); pulseB();
    check("R8", "counts with gate open", cUpCnt, 2);
    setup(4'b1111, 2'b00, 2'b00, 1'b0, 1'b0);
    check("R8", "B gate low level", int'(gateLvl), 0);
    setup(4'b1111, 2'b00, 2'b00, 1'b0, 1'b1);
    check("R6", "B gate with bivalue", int'(gateLvl), 1);
  endtask

  task automatic testUpDownClk;
    setup(4'b1000, 2'b01, 2'b01, 1'b0, 1'b0);
    pulseA(); pulseA();
    pulseB();
    check("R9", "up clocks", cUpCnt, 2);
    check("R9", "down clocks", cDnCnt, 1);
    clearCounts();
    @(negedge clk); pinA = 1'b1; pinB = 1'b1;
    repeat (8) @(negedge clk);
    check("R9", "simultaneous up count", cUpCnt, 0);
    check("R9", "simultaneous down count", cDnCnt, 0);
  endtask

  task automatic testTrigDir;
    setup(4'b1010, 2'b01, 2'b01, 1'b0, 1'b0);
    pulseA(); pulseB(); pulseB();
    check("R10", "up start strobes", cUpOnly, 1);
    check("R10", "down start strobes", cDnOnly, 2);
    check("R10", "no count/load/capture", cUpCnt + cDnCnt + cLoad + cCap0 + cCap1, 0);
  endtask

  task automatic testAuto;
    setup(4'b1100, 2'b01, 2'b01, 1'b0, 1'b0);
    pulseA();
    check("R11", "A leads B -> up", cUpCnt, 1);
    driveB(1'b1);
    pulseA();
    check("R11", "B high -> down", cDnCnt, 1);
    driveB(1'b0);
    check("R11", "B edges ignored", cUpCnt + cDnCnt, 2);
  endtask

  task automatic testIdle;
    setup(4'b0000, 2'b11, 2'b11, 1'b0, 1'b0);
    pulseA(); pulseB();
    check("R13", "mode 0000 strobes",
          cUpCnt + cDnCnt + cUpOnly + cDnOnly + cLoad + cCap0 + cCap1, 0);
    setup(4'b1011, 2'b01, 2'b01, 1'b0, 1'b0);
    pulseA(); pulseB();
    check("R13", "mode 1011 strobes",
          cUpCnt + cDnCnt + cUpOnly + cDnOnly + cLoad + cCap0 + cCap1, 0);
    check("R12", "count pulses with bad direction", cBadDir, 0);
  endtask

  initial begin
    #(8 * 150000);
    nErrs++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testLatency();
    testEdgeSel();
    testTrigA();
    testTrigB();
    testExtClk();
    testGate();
    testUpDownClk();
    testTrigDir();
    testAuto();
    testIdle();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule